// File: doc/BRIEF.md
# CCM Phase Controller

This block is the control and status logic for a 128-bit block-cipher accelerator that runs counter-with-CBC-MAC authenticated encryption. Software configures it through a write port that carries an enable bit, a chaining selector, a two-bit phase number and a two-bit operating mode. The block then sequences the four CCM phases: init, header (associated data), payload and final. It issues single-cycle start requests to an external cipher engine, which returns a done pulse and a result block.

The block checks every configuration write. Under CCM it refuses the key-derivation mode and any phase jump that breaks the CCM order. While a computation runs, it accepts only a request to drop the enable bit. In the init and final phases, setting enable starts the engine on the initial-vector block, and the hardware clears enable again once the engine finishes. In the header and payload phases, each data write starts one block while enable stays set. A partial last header block has its unused trailing bytes forced to zero. A completion flag reports each finished block. The output data register is marked valid only for results of the payload and final phases.

Top module: `ccm_phase_ctrl`

## Requirements
- R1: After reset, en, chain, phase, mode, ccf, mode_err, seq_err, wr_err, eng_start and dout_vld are all 0.
- R2: A write with cfg_chain = 3'b100 (CCM) and cfg_mode = 2'b01 (key derivation) sets mode_err. None of its fields, enable included, is applied. Under CCM, mode is never 2'b01.
- R3: While en = 1, a configuration write with cfg_en = 0 clears en, and any other content of the write is ignored. chain, phase and mode keep their values.
- R4: For a write with cfg_chain = 3'b100 while en = 0, the phase codes are init 2'b00, header 2'b01, payload 2'b10 and final 2'b11. The new phase is accepted if it equals the current phase, is the next one, is init, or is payload when the current phase is init (header skipped). Any other phase sets seq_err and drops the whole write.
- R5: An accepted write with cfg_en = 1 and phase init or final raises eng_start for exactly the next cycle, with eng_blk equal to iv. Once the engine completes, en returns to 0 with no software action.
- R6: In the header or payload phase, with en = 1, the engine idle and ccf = 0, a din_we pulse raises eng_start in the next cycle with the (header-padded) data block. en stays 1 after that block completes.
- R7: An eng_done pulse for an outstanding request sets ccf. A flag_clr pulse clears ccf, wr_err, mode_err and seq_err.
- R8: A din_we pulse while ccf = 1 sets wr_err and starts no engine request.
- R9: Byte b of a block is bits [127-8b -: 8]. In the header phase, when din_last = 1 and din_bytes < 16, every byte b >= din_bytes goes to the engine as zero. Payload blocks and non-last header blocks go through unmasked.
- R10: dout_vld rises, and dout captures eng_res, only when a computation in the payload or final phase completes. Init and header completions leave dout_vld at 0. dout_vld clears on the next engine start or on any accepted configuration write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Enable value to write |
| cfg_chain | input | 3 | Chaining selector to write (3'b100 = CCM) |
| cfg_phase | input | 2 | Phase number to write |
| cfg_mode | input | 2 | Operating mode to write |
| flag_clr | input | 1 | Clear completion and error flags |
| din_we | input | 1 | Data block write strobe |
| din | input | 128 | Data block |
| din_last | input | 1 | Marks the last header block |
| din_bytes | input | 5 | Valid byte count of the last header block |
| iv | input | 128 | Initial-vector block |
| eng_done | input | 1 | Engine completion pulse |
| eng_res | input | 128 | Engine result block |
| en | output | 1 | Enable state |
| chain | output | 3 | Active chaining selector |
| phase | output | 2 | Active phase |
| mode | output | 2 | Active operating mode |
| ccf | output | 1 | Computation-complete flag, usable as interrupt |
| mode_err | output | 1 | Forbidden mode write seen |
| seq_err | output | 1 | Illegal phase transition write seen |
| wr_err | output | 1 | Data written while ccf still set |
| eng_start | output | 1 | One-cycle engine start request |
| eng_blk | output | 128 | Block presented to the engine |
| dout | output | 128 | Output data register |
| dout_vld | output | 1 | Output data register holds valid data |

## Verification
The hardest case to reach from the ports is a locked configuration write: a write that arrives while a computation is running and enable is still set. The stimulus enables the init phase and, while the stubbed engine holds back its done pulse, writes a different phase and mode with enable still requested. The bench then confirms that the fields are unchanged and that enable falls only when the delayed done arrives. The padding masks are exercised from a vector table that covers the counts 0, 1, 8 and 15, a full block, and a non-last block. The bench also walks the header, payload, final and skip transitions so that each allowed and refused phase step is observed on the ports.

// File: rtl/ccm_ctrl_pkg.sv
package ccm_ctrl_pkg;

  typedef enum logic [1:0] {
    PH_INIT = 2'b00,
    PH_HDR  = 2'b01,
    PH_PLD  = 2'b10,
    PH_FIN  = 2'b11
  } ccm_phase_e;

  localparam logic [2:0] CHAIN_CCM   = 3'b100;
  localparam logic [1:0] MODE_KDERIV = 2'b01;

  typedef struct packed {
    logic [2:0] chain;
    ccm_phase_e phase;
    logic [1:0] mode;
  } ccm_cfg_t;

endpackage

// File: rtl/ccm_cfg_regs.sv
module ccm_cfg_regs
  import ccm_ctrl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cfg_we,
  input  logic     cfg_en,
  input  ccm_cfg_t cfg_in,
  input  logic     flag_clr,
  input  logic     done_ok,
  output logic     en,
  output ccm_cfg_t cfg_q,
  output logic     mode_err,
  output logic     seq_err,
  output logic     acc,
  output logic     go
);

  logic bad_mode, seq_ok, is_ccm;
  logic en_d, me_d, se_d;
  logic [1:0] cur_ph, new_ph;

  always_comb begin
    cur_ph   = cfg_q.phase;
    new_ph   = cfg_in.phase;
    is_ccm   = (cfg_in.chain == CHAIN_CCM);
    bad_mode = is_ccm && (cfg_in.mode == MODE_KDERIV);
    seq_ok   = !is_ccm || (new_ph == cur_ph) || (new_ph == PH_INIT) ||
               (new_ph == cur_ph + 2'd1) ||
               ((cur_ph == PH_INIT) && (new_ph == PH_PLD));
    acc      = cfg_we && !en && !bad_mode && seq_ok;
    go       = acc && cfg_en && ((new_ph == PH_INIT) || (new_ph == PH_FIN));

    en_d = en;
    if (cfg_we && en && !cfg_en)
      en_d = 1'b0;
    else if (acc)
      en_d = cfg_en;
    else if (done_ok && ((cur_ph == PH_INIT) || (cur_ph == PH_FIN)))
      en_d = 1'b0;

    me_d = (mode_err && !flag_clr) || (cfg_we && !en && bad_mode);
    se_d = (seq_err && !flag_clr) || (cfg_we && !en && !bad_mode && !seq_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= 1'b0;
      cfg_q    <= '{chain: 3'b000, phase: PH_INIT, mode: 2'b00};
      mode_err <= 1'b0;
      seq_err  <= 1'b0;
    end else begin
      en       <= en_d;
      mode_err <= me_d;
      seq_err  <= se_d;
      if (acc) cfg_q <= cfg_in;
    end
  end

endmodule

// File: rtl/ccm_hdr_pad.sv
module ccm_hdr_pad #(
  parameter int BLK_BYTES = 16,
  localparam int BLK_W = BLK_BYTES * 8,
  localparam int CNT_W = $clog2(BLK_BYTES + 1)
) (
  input  logic [BLK_W-1:0] din,
  input  logic             last,
  input  logic [CNT_W-1:0] nbytes,
  input  logic             pad_en,
  output logic [BLK_W-1:0] blk
);

  logic partial;
  assign partial = pad_en && last && (nbytes < CNT_W'(BLK_BYTES));

  for (genvar b = 0; b < BLK_BYTES; b++) begin : g_byte
    logic keep;
    assign keep = !partial || (CNT_W'(b) < nbytes);
    assign blk[BLK_W-1-8*b -: 8] = keep ? din[BLK_W-1-8*b -: 8] : 8'h00;
  end

endmodule

// File: rtl/ccm_blk_seq.sv
module ccm_blk_seq
  import ccm_ctrl_pkg::*;
#(
  parameter int BLK_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             acc,
  input  logic             en,
  input  ccm_phase_e       phase,
  input  logic             din_we,
  input  logic [BLK_W-1:0] din_blk,
  input  logic [BLK_W-1:0] iv,
  input  logic             eng_done,
  input  logic [BLK_W-1:0] eng_res,
  input  logic             flag_clr,
  output logic             eng_start,
  output logic [BLK_W-1:0] eng_blk,
  output logic             busy,
  output logic             ccf,
  output logic             wr_err,
  output logic [BLK_W-1:0] dout,
  output logic             dout_vld,
  output logic             done_ok
);

  logic feed, start_d, busy_d, ccf_d, we_d, dv_d, dout_ld;

  always_comb begin
    done_ok = eng_done && busy;
    feed    = din_we && en && !busy && !ccf &&
              ((phase == PH_HDR) || (phase == PH_PLD));
    start_d = go || feed;
    busy_d  = start_d ? 1'b1 : (done_ok ? 1'b0 : busy);
    ccf_d   = done_ok ? 1'b1 : (flag_clr ? 1'b0 : ccf);
    we_d    = (din_we && ccf) ? 1'b1 : (flag_clr ? 1'b0 : wr_err);
    dout_ld = done_ok && ((phase == PH_PLD) || (phase == PH_FIN));
    dv_d    = dout_ld ? 1'b1 : ((start_d || acc) ? 1'b0 : dout_vld);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_start <= 1'b0;
      eng_blk   <= '0;
      busy      <= 1'b0;
      ccf       <= 1'b0;
      wr_err    <= 1'b0;
      dout      <= '0;
      dout_vld  <= 1'b0;
    end else begin
      eng_start <= start_d;
      busy      <= busy_d;
      ccf       <= ccf_d;
      wr_err    <= we_d;
      dout_vld  <= dv_d;
      if (start_d) eng_blk <= go ? iv : din_blk;
      if (dout_ld) dout <= eng_res;
    end
  end

endmodule

// File: rtl/ccm_phase_ctrl.sv
module ccm_phase_ctrl
  import ccm_ctrl_pkg::*;
#(
  parameter int BLK_BYTES = 16,
  localparam int BLK_W = BLK_BYTES * 8,
  localparam int CNT_W = $clog2(BLK_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_en,
  input  logic [2:0]       cfg_chain,
  input  logic [1:0]       cfg_phase,
  input  logic [1:0]       cfg_mode,
  input  logic             flag_clr,
  input  logic             din_we,
  input  logic [BLK_W-1:0] din,
  input  logic             din_last,
  input  logic [CNT_W-1:0] din_bytes,
  input  logic [BLK_W-1:0] iv,
  input  logic             eng_done,
  input  logic [BLK_W-1:0] eng_res,
  output logic             en,
  output logic [2:0]       chain,
  output logic [1:0]       phase,
  output logic [1:0]       mode,
  output logic             ccf,
  output logic             mode_err,
  output logic             seq_err,
  output logic             wr_err,
  output logic             eng_start,
  output logic [BLK_W-1:0] eng_blk,
  output logic [BLK_W-1:0] dout,
  output logic             dout_vld
);

  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  ccm_cfg_t         cfg_in, cfg_q;
  logic             acc, go, done_ok, busy_w;
  logic [BLK_W-1:0] pad_blk;

  assign cfg_in = '{chain: cfg_chain, phase: ccm_phase_e'(cfg_phase), mode: cfg_mode};

  ccm_cfg_regs u_cfg (
    .clk     (clk),
    .rst_n   (rst_sn),
    .cfg_we  (cfg_we),
    .cfg_en  (cfg_en),
    .cfg_in  (cfg_in),
    .flag_clr(flag_clr),
    .done_ok (done_ok),
    .en      (en),
    .cfg_q   (cfg_q),
    .mode_err(mode_err),
    .seq_err (seq_err),
    .acc     (acc),
    .go      (go)
  );

  ccm_hdr_pad #(.BLK_BYTES(BLK_BYTES)) u_pad (
    .din   (din),
    .last  (din_last),
    .nbytes(din_bytes),
    .pad_en(cfg_q.phase == PH_HDR),
    .blk   (pad_blk)
  );

  ccm_blk_seq #(.BLK_W(BLK_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sn),
    .go       (go),
    .acc      (acc),
    .en       (en),
    .phase    (cfg_q.phase),
    .din_we   (din_we),
    .din_blk  (pad_blk),
    .iv       (iv),
    .eng_done (eng_done),
    .eng_res  (eng_res),
    .flag_clr (flag_clr),
    .eng_start(eng_start),
    .eng_blk  (eng_blk),
    .busy     (busy_w),
    .ccf      (ccf),
    .wr_err   (wr_err),
    .dout     (dout),
    .dout_vld (dout_vld),
    .done_ok  (done_ok)
  );

  assign chain = cfg_q.chain;
  assign phase = cfg_q.phase;
  assign mode  = cfg_q.mode;

endmodule

// File: rtl/ccm_phase_ctrl_chk.sv
module ccm_phase_ctrl_chk (
  input logic       clk,
  input logic       rst_sn,
  input logic       cfg_we,
  input logic       din_we,
  input logic       eng_done,
  input logic       busy,
  input logic       en,
  input logic [2:0] chain,
  input logic [1:0] phase,
  input logic [1:0] mode,
  input logic       ccf,
  input logic       wr_err,
  input logic       eng_start,
  input logic       dout_vld
);

  // R2
  ccm_mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (chain == 3'b100) |-> (mode != 2'b01));

  // R3
  locked_cfg_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (en && cfg_we) |=> ($stable(chain) && $stable(mode) && $stable(phase)));

  // R5
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (en && !cfg_we && !eng_done) |=> en);

  // R7
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (eng_done && busy) |=> ccf);

  // R8
  blocked_din_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (din_we && ccf && !cfg_we) |=> (wr_err && !eng_start));

  // R10
  dout_phase_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    dout_vld |-> phase[1]);

endmodule

bind ccm_phase_ctrl ccm_phase_ctrl_chk u_chk (
  .clk      (clk),
  .rst_sn   (rst_sn),
  .cfg_we   (cfg_we),
  .din_we   (din_we),
  .eng_done (eng_done),
  .busy     (busy_w),
  .en       (en),
  .chain    (chain),
  .phase    (phase),
  .mode     (mode),
  .ccf      (ccf),
  .wr_err   (wr_err),
  .eng_start(eng_start),
  .dout_vld (dout_vld)
);

// File: tb/sim_ccm_phase_ctrl.sv
`timescale 1ns/1ps
module sim_ccm_phase_ctrl;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0, cfg_en = 1'b0;
  logic [2:0]   cfg_chain = '0;
  logic [1:0]   cfg_phase = '0, cfg_mode = '0;
  logic         flag_clr = 1'b0, din_we = 1'b0, din_last = 1'b0;
  logic [127:0] din = '0, iv, eng_res = '0;
  logic [4:0]   din_bytes = '0;
  logic         eng_done = 1'b0;
  logic         en, ccf, mode_err, seq_err, wr_err, eng_start, dout_vld;
  logic [2:0]   chain;
  logic [1:0]   phase, mode;
  logic [127:0] eng_blk, dout;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  ccm_phase_ctrl u0 (.*);

  localparam logic [2:0] CCM = 3'b100;
  localparam int NV = 6;
  localparam logic [4:0] VB [NV] = '{5'd16, 5'd15, 5'd1, 5'd0, 5'd8, 5'd3};
  localparam logic       VL [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic e, input logic [2:0] c, input logic [1:0] p, input logic [1:0] m);
    @(negedge clk);
    cfg_we = 1'b1; cfg_en = e; cfg_chain = c; cfg_phase = p; cfg_mode = m;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic din_wr(input logic [127:0] d, input logic l, input logic [4:0] n);
    @(negedge clk);
    din_we = 1'b1; din = d; din_last = l; din_bytes = n;
    @(negedge clk);
    din_we = 1'b0;
  endtask

  task automatic finish_eng(input logic [127:0] r);
    repeat (2) @(negedge clk);
    eng_done = 1'b1; eng_res = r;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  task automatic clr;
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  function automatic logic [127:0] pad_exp(input logic [127:0] d, input logic l, input logic [4:0] n);
    for (int b = 0; b < 16; b++)
      if (l && n < 5'd16 && b >= int'(n)) d[127-8*b -: 8] = 8'h00;
    return d;
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    iv = {4{32'hC0DE_0001}};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 en", en, 0); check("R1 ccf", ccf, 0); check("R1 phase", phase, 0);
    check("R1 chain", chain, 0); check("R1 dout_vld", dout_vld, 0);
    check("R1 errs", {mode_err, seq_err, wr_err, eng_start}, 0);

    // R2 forbidden mode
    cfg_wr(1, CCM, 2'b00, 2'b01);
    check("R2 mode_err", mode_err, 1); check("R2 en", en, 0); check("R2 chain", chain, 0);
    clr();
    check("R7 clear mode_err", mode_err, 0);

    // R5 init enable starts engine on iv
    cfg_wr(1, CCM, 2'b00, 2'b00);
    check("R5 start", eng_start, 1); check("R5 blk", eng_blk, iv); check("R5 en", en, 1);
    @(negedge clk);
    check("R5 single pulse", eng_start, 0);
    // R3 locked write while busy
    cfg_wr(1, CCM, 2'b01, 2'b10);
    check("R3 mode", mode, 0); check("R3 phase", phase, 0); check("R3 en", en, 1);
    finish_eng(128'h1111);
    check("R5 en self clear", en, 0); check("R7 ccf", ccf, 1); check("R10 init no dout", dout_vld, 0);

    // R8 write with ccf set
    din_wr(128'hDEAD, 0, 0);
    check("R8 wr_err", wr_err, 1); check("R8 no start", eng_start, 0);
    clr();
    check("R7 clear ccf", ccf, 0); check("R7 clear wr_err", wr_err, 0);

    // R4 illegal init->final
    cfg_wr(0, CCM, 2'b11, 2'b00);
    check("R4 seq_err", seq_err, 1); check("R4 phase kept", phase, 0);
    clr();

    // R6/R9 header vectors
    cfg_wr(1, CCM, 2'b01, 2'b00);
    check("R4 init->hdr", phase, 1);
    for (int i = 0; i < NV; i++) begin
      logic [127:0] d;
      d = {16{8'(8'h21 + 8'(i * 17))}} ^ {4{32'h0F1E_2D3C}};
      din_wr(d, VL[i], VB[i]);
      check("R6 hdr start", eng_start, 1);
      check("R9 pad", eng_blk, pad_exp(d, VL[i], VB[i]));
      finish_eng(~d);
      check("R6 en kept", en, 1); check("R10 hdr no dout", dout_vld, 0);
      clr();
    end

    // R3 disable only
    cfg_wr(0, 3'b000, 2'b11, 2'b10);
    check("R3 disable", en, 0); check("R3 chain kept", chain, CCM);
    cfg_wr(1, CCM, 2'b10, 2'b00);
    check("R4 hdr->pld", phase, 2); check("R4 no err", seq_err, 0);
    din_wr(128'hABCD_EF01, 1, 3);
    check("R9 payload unpadded", eng_blk, 128'hABCD_EF01);
    finish_eng(128'h5A5A);
    check("R10 pld dout_vld", dout_vld, 1); check("R10 dout", dout, 128'h5A5A);
    check("R6 pld en kept", en, 1);
    clr();

    // final phase
    cfg_wr(0, 3'b000, 2'b00, 2'b00);
    cfg_wr(1, CCM, 2'b11, 2'b00);
    check("R5 fin start", eng_start, 1); check("R5 fin blk", eng_blk, iv);
    check("R10 cleared on start", dout_vld, 0);
    finish_eng(128'h7777);
    check("R5 fin en clear", en, 0); check("R10 fin dout", dout, 128'h7777);
    check("R10 fin vld", dout_vld, 1);
    clr();

    // R4 fin->hdr illegal, fin->init legal, init->pld skip
    cfg_wr(0, CCM, 2'b01, 2'b00);
    check("R4 fin->hdr err", seq_err, 1); check("R4 phase fin", phase, 3);
    cfg_wr(0, CCM, 2'b00, 2'b10);
    check("R4 fin->init", phase, 0); check("R10 cleared on cfg", dout_vld, 0);
    clr();
    cfg_wr(0, CCM, 2'b10, 2'b10);
    check("R4 skip header", phase, 2); check("R4 skip no err", seq_err, 0);
    check("R2 mode 10 ok", mode, 2);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule